// File: doc/BRIEF.md
# Five-Round-Per-Clock Bitsliced Block Encryptor

This core encrypts 64-bit blocks with a 25-round bitsliced substitution-permutation cipher. It trades area for speed: a chain of rounds with no registers between them sits in front of one 64-bit state register. Each clock pushes the state through the whole chain, so five register updates complete a block. By default the chain holds five rounds and runs five steps. The key is fixed when the design is built. Every round subkey, plus one final whitening key, is worked out by a constant function at elaboration. The keys are held in a ROM that is read at the current step number. No key schedule runs in hardware.

To use it, hold `ld` high for one clock with the plaintext on `din`. The core runs the steps by itself. It raises `done` for one cycle, and at that point `dout` carries the ciphertext. The result stays on `dout` until the next load. A new load is accepted in any cycle, including the cycle in which `done` is high. A load made while a block is in flight drops that block and starts over.

Top module: `ucr_core`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `busy`, `done` and `dout` are all zero.
- R2: A clock edge with `ld` high copies `din` into the state. From the next cycle `dout` equals that `din`, `busy` is 1 and the step counter is zero. `ld` takes priority over any step in progress.
- R3: Each clock edge with `busy` high and `ld` low applies RPI rounds to the state. One round does the following, in order:
  - XOR the subkey into the state.
  - Apply the S-box to each of the 16 columns. Row i is bits [16i+15:16i]. Column c forms the nibble {row3[c], row2[c], row1[c], row0[c]} and is mapped through 6,5,C,A,1,E,7,9,B,0,3,D,8,F,4,2 (hex, indexed 0 to F).
  - Rotate rows 0, 1, 2 and 3 left by 0, 1, 12 and 13 bits, where left means that bit b moves to bit b+n mod 16.
- R4: Subkey n is the low 64 bits of an 80-bit key register. The register starts at parameter KEY. Rows 0 to 4 are its 16-bit slices from bit 0 upward, and subkey n is {row3, row2, row1, row0}. One update does the following, in order:
  - Apply the S-box to columns 0 to 3 of rows 0 to 3.
  - Form the new rows: row0 = rotl8(row0) ^ row1, row1 = row2, row2 = row3, row3 = rotl12(row3) ^ row4, row4 = old row0 after the S-box.
  - XOR a 5-bit constant into bits [4:0] of the new row0. The constant starts at 1 and then moves to {c[3:0], c[4]^c[2]}.
  Step s uses subkeys s*RPI to s*RPI+RPI-1.
- R5: On the last of the NIT steps the final subkey (index RPI*NIT) is also XORed in. In the next cycle `done` is high for exactly one cycle, `busy` is low and `dout` is the ciphertext. This is NIT cycles after the load edge.
- R6: While the core is idle (`busy` low) and `ld` is low, `dout` holds its value whatever `din` does, and `done` stays low.
- R7: A load made while `busy` is high drops the current block, restarts the step count at zero and produces a result NIT cycles later.
- R8: A load made in the cycle in which `done` is high is accepted, so blocks can follow each other with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld | input | 1 | Load `din` and start a block |
| din | input | 64 | Plaintext block |
| dout | output | 64 | State register: plaintext after load, ciphertext after done |
| done | output | 1 | One-cycle pulse when the ciphertext is on `dout` |
| busy | output | 1 | A block is being encrypted |

## Verification
The bench builds the core with five rounds per step, five steps and a non-zero 80-bit key. These values exercise all 26 ROM entries and every round-constant value the schedule produces. The step-to-ROM address mapping is covered at every step, and so is the fold of the final key into the last step. The reference model checks `dout` in every busy cycle, so any wrong subkey, S-box entry or rotation shows up at the step where it first occurs. The stimulus also covers:
- a reload in the middle of a block;
- a reload in the same cycle as `done`;
- `ld` held high for two cycles;
- `din` changing while the core is idle.

// File: rtl/ucr_pkg.sv
package ucr_pkg;
   localparam int ROW_W = 16;
   localparam int NROWS = 4;
   localparam int BLK_W = ROW_W * NROWS;
   localparam int KROWS = 5;
   localparam int KEY_W = ROW_W * KROWS;

   typedef logic [BLK_W-1:0] blk_t;
   typedef logic [KEY_W-1:0] key_t;
   typedef logic [ROW_W-1:0] row_t;

   function automatic logic [3:0] sbox4(input logic [3:0] a);
      logic [3:0] r;
      case (a)
         4'h0: r = 4'h6;  4'h1: r = 4'h5;  4'h2: r = 4'hC;  4'h3: r = 4'hA;
         4'h4: r = 4'h1;  4'h5: r = 4'hE;  4'h6: r = 4'h7;  4'h7: r = 4'h9;
         4'h8: r = 4'hB;  4'h9: r = 4'h0;  4'hA: r = 4'h3;  4'hB: r = 4'hD;
         4'hC: r = 4'h8;  4'hD: r = 4'hF;  4'hE: r = 4'h4;  default: r = 4'h2;
      endcase
      return r;
   endfunction

   function automatic row_t rotl(input row_t x, input int n);
      row_t r;
      for (int b = 0; b < ROW_W; b++) r[(b + n) % ROW_W] = x[b];
      return r;
   endfunction

   function automatic int row_rot(input int i);
      case (i)
         0: return 0;
         1: return 1;
         2: return 12;
         default: return 13;
      endcase
   endfunction

   // S-box over the first ncol columns of a 4-row slice
   function automatic blk_t sub_cols(input blk_t x, input int ncol);
      blk_t y;
      logic [3:0] nib;
      y = x;
      for (int c = 0; c < ncol; c++) begin
         nib = sbox4({x[3*ROW_W+c], x[2*ROW_W+c], x[ROW_W+c], x[c]});
         for (int r = 0; r < NROWS; r++) y[r*ROW_W+c] = nib[r];
      end
      return y;
   endfunction

   function automatic blk_t perm_rows(input blk_t x);
      blk_t y;
      for (int r = 0; r < NROWS; r++)
         y[r*ROW_W +: ROW_W] = rotl(x[r*ROW_W +: ROW_W], row_rot(r));
      return y;
   endfunction

   function automatic key_t key_step(input key_t k, input logic [4:0] rc);
      blk_t lo;
      row_t w0, w1, w2, w3, w4;
      lo = sub_cols(k[BLK_W-1:0], 4);
      w0 = lo[0 +: ROW_W];
      w1 = lo[ROW_W +: ROW_W];
      w2 = lo[2*ROW_W +: ROW_W];
      w3 = lo[3*ROW_W +: ROW_W];
      w4 = k[4*ROW_W +: ROW_W];
      w4 = w4;
      begin
         row_t n0, n3;
         n0 = rotl(w0, 8) ^ w1;
         n0[4:0] = n0[4:0] ^ rc;
         n3 = rotl(w3, 12) ^ w4;
         return {w0, n3, w3, w2, n0};
      end
   endfunction

   function automatic logic [4:0] rc_next(input logic [4:0] c);
      return {c[3:0], c[4] ^ c[2]};
   endfunction
endpackage

// File: rtl/ucr_round.sv
module ucr_round
   import ucr_pkg::*;
(
   input  logic [BLK_W-1:0] st,
   input  logic [BLK_W-1:0] rk,
   output logic [BLK_W-1:0] nx
);
   logic [BLK_W-1:0] keyed;
   logic [BLK_W-1:0] subbed;

   always_comb begin
      keyed  = st ^ rk;
      subbed = sub_cols(keyed, ROW_W);
      nx     = perm_rows(subbed);
   end
endmodule

// File: rtl/ucr_keyrom.sv
module ucr_keyrom
   import ucr_pkg::*;
#(
   parameter int          RPI   = 5,
   parameter int          NIT   = 5,
   parameter logic [79:0] KEY   = '0,
   parameter int          CNT_W = 3
) (
   input  logic [CNT_W-1:0]     step,
   output logic [RPI*BLK_W-1:0] rk_flat,
   output logic [BLK_W-1:0]     rk_fin
);
   localparam int NK    = RPI * NIT + 1;
   localparam int IDX_W = (NK > 1) ? $clog2(NK) : 1;

   function automatic blk_t key_at(input int idx);
      key_t       k;
      logic [4:0] c;
      k = KEY;
      c = 5'h01;
      for (int n = 0; n < idx; n++) begin
         k = key_step(k, c);
         c = rc_next(c);
      end
      return k[BLK_W-1:0];
   endfunction

   logic [BLK_W-1:0] tab [NK];

   for (genvar i = 0; i < NK; i++) begin : g_tab
      localparam blk_t KV = key_at(i);
      assign tab[i] = KV;
   end

   for (genvar r = 0; r < RPI; r++) begin : g_rd
      logic [31:0] addr;
      assign addr = 32'(step) * 32'(RPI) + 32'(r);
      assign rk_flat[r*BLK_W +: BLK_W] = tab[addr[IDX_W-1:0]];
   end

   assign rk_fin = tab[NK-1];
endmodule

// File: rtl/ucr_ctrl.sv
module ucr_ctrl #(
   parameter int NIT   = 5,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   output logic [CNT_W-1:0] step,
   output logic             busy,
   output logic             last,
   output logic             done
);
   assign last = busy && (step == CNT_W'(NIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (ld) begin
            step <= '0;
            busy <= 1'b1;
         end else if (busy) begin
            if (last) begin
               step <= '0;
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               step <= step + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/ucr_core.sv
module ucr_core
   import ucr_pkg::*;
#(
   parameter int          RPI = 5,
   parameter int          NIT = 5,
   parameter logic [79:0] KEY = 80'h0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ld,
   input  logic [63:0] din,
   output logic [63:0] dout,
   output logic        done,
   output logic        busy
);
   localparam int CNT_W = (NIT > 1) ? $clog2(NIT) : 1;

   if (RPI < 1 || NIT < 1) begin : g_bad_count
      $error("ucr_core: RPI and NIT must both be at least 1");
   end
   if (BLK_W != 64 || KEY_W != 80) begin : g_bad_width
      $error("ucr_core: package widths must be 64-bit block and 80-bit key");
   end

   logic [CNT_W-1:0]     step;
   logic                 last;
   logic [RPI*BLK_W-1:0] rk_flat;
   logic [BLK_W-1:0]     rk_fin;
   logic [BLK_W-1:0]     state;
   logic [BLK_W-1:0]     lane [RPI+1];

   ucr_ctrl #(.NIT(NIT), .CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .ld(ld),
      .step(step), .busy(busy), .last(last), .done(done)
   );

   ucr_keyrom #(.RPI(RPI), .NIT(NIT), .KEY(KEY), .CNT_W(CNT_W)) u_rom (
      .step(step), .rk_flat(rk_flat), .rk_fin(rk_fin)
   );

   assign lane[0] = state;
   for (genvar r = 0; r < RPI; r++) begin : g_chain
      ucr_round u_rnd (
         .st(lane[r]),
         .rk(rk_flat[r*BLK_W +: BLK_W]),
         .nx(lane[r+1])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      state <= '0;
      else if (ld)     state <= din;
      else if (last)   state <= lane[RPI] ^ rk_fin;
      else if (busy)   state <= lane[RPI];
   end

   assign dout = state;
endmodule

// File: rtl/ucr_core_chk.sv
module ucr_core_chk #(
   parameter int NIT   = 5,
   parameter int CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ld,
   input logic [63:0]      din,
   input logic [63:0]      dout,
   input logic             done,
   input logic             busy,
   input logic [CNT_W-1:0] step
);
   // R2
   load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (busy && dout == $past(din) && step == '0));
   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R5
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !ld) |=> ($stable(dout) && !done));
   // R7
   step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(step) < NIT);
endmodule

bind ucr_core ucr_core_chk #(.NIT(NIT), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ld(ld), .din(din), .dout(dout),
   .done(done), .busy(busy), .step(step)
);

// File: tb/ucr_core_bench.sv
module ucr_core_bench;
   localparam int          CLK_P = 10;
   localparam int          RPI   = 5;
   localparam int          NIT   = 5;
   localparam int          NK    = RPI * NIT + 1;
   localparam logic [79:0] KEY_B = 80'h0123_4567_89AB_CDEF_F00D;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld = 1'b0;
   logic [63:0] din = '0;
   logic [63:0] dout;
   logic        done, busy;

   ucr_core #(.RPI(RPI), .NIT(NIT), .KEY(KEY_B)) u_ucr_core (
      .clk(clk), .rst_n(rst_n), .ld(ld), .din(din),
      .dout(dout), .done(done), .busy(busy)
   );

   always #(CLK_P/2) clk = ~clk;

   int          vectors = 0;
   int          miscompares = 0;
   int          cycles = 0;
   string       phase = "";
   logic [63:0] keys [NK];

   function automatic logic [3:0] m_sb(input logic [3:0] a);
      logic [3:0] t [16] = '{4'h6,4'h5,4'hC,4'hA,4'h1,4'hE,4'h7,4'h9,
                             4'hB,4'h0,4'h3,4'hD,4'h8,4'hF,4'h4,4'h2};
      return t[a];
   endfunction

   function automatic logic [15:0] m_rot(input logic [15:0] x, input int n);
      logic [31:0] d;
      d = {x, x} << n;
      return d[31:16];
   endfunction

   function automatic logic [63:0] m_round(input logic [63:0] s, input logic [63:0] k);
      logic [63:0] x, y;
      logic [3:0]  o;
      int          rot [4] = '{0, 1, 12, 13};
      x = s ^ k;
      for (int c = 0; c < 16; c++) begin
         o = m_sb({x[48+c], x[32+c], x[16+c], x[c]});
         for (int r = 0; r < 4; r++) y[16*r+c] = o[r];
      end
      for (int r = 0; r < 4; r++) x[16*r +: 16] = m_rot(y[16*r +: 16], rot[r]);
      return x;
   endfunction

   task automatic make_keys();
      logic [15:0] w [5];
      logic [15:0] a, e;
      logic [4:0]  rc;
      logic [3:0]  o;
      rc = 5'd1;
      for (int i = 0; i < 5; i++) w[i] = KEY_B[16*i +: 16];
      for (int n = 0; n < NK; n++) begin
         keys[n] = {w[3], w[2], w[1], w[0]};
         for (int c = 0; c < 4; c++) begin
            o = m_sb({w[3][c], w[2][c], w[1][c], w[0][c]});
            for (int r = 0; r < 4; r++) w[r][c] = o[r];
         end
         a = m_rot(w[0], 8) ^ w[1];
         a[4:0] = a[4:0] ^ rc;
         e = m_rot(w[3], 12) ^ w[4];
         w[4] = w[0];
         w[0] = a;
         w[1] = w[2];
         w[2] = w[3];
         w[3] = e;
         rc = {rc[3:0], rc[4] ^ rc[2]};
      end
   endtask

   // reference model
   logic [63:0] e_st = '0;
   logic        e_busy = 1'b0, e_done = 1'b0, e_ld = 1'b0;
   int          e_cnt = 0;

   always @(posedge clk) begin
      logic [63:0] t;
      if (!rst_n) begin
         e_st <= '0; e_busy <= 1'b0; e_done <= 1'b0; e_cnt <= 0; e_ld <= 1'b0;
      end else begin
         e_done <= 1'b0;
         e_ld   <= ld;
         if (ld) begin
            e_st <= din; e_cnt <= 0; e_busy <= 1'b1;
         end else if (e_busy) begin
            t = e_st;
            for (int r = 0; r < RPI; r++) t = m_round(t, keys[e_cnt*RPI + r]);
            if (e_cnt == NIT - 1) begin
               t = t ^ keys[NK-1];
               e_busy <= 1'b0; e_done <= 1'b1; e_cnt <= 0;
            end else begin
               e_cnt <= e_cnt + 1;
            end
            e_st <= t;
         end
      end
   end

   always @(negedge clk) begin
      string rq;
      if (rst_n) begin
         vectors++;
         if (e_ld)        rq = "R2";
         else if (e_done) rq = "R5";
         else if (e_busy) rq = "R3 R4";
         else             rq = "R6";
         if (dout !== e_st) begin
            miscompares++;
            $display("FAIL %s %s dout actual=%h expected=%h", rq, phase, dout, e_st);
         end
         if (done !== e_done) begin
            miscompares++;
            $display("FAIL R5 %s done actual=%b expected=%b", phase, done, e_done);
         end
         if (busy !== e_busy) begin
            miscompares++;
            $display("FAIL R2 R5 %s busy actual=%b expected=%b", phase, busy, e_busy);
         end
      end
   end

   task automatic drive(input logic l, input logic [63:0] d);
      @(negedge clk);
      #1;
      ld = l;
      din = d;
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         miscompares++;
         $display("FAIL watchdog expired actual=%0d expected<=20000 cycles", cycles);
         finish_run();
      end
   end

   initial begin
      make_keys();
      repeat (3) @(posedge clk);
      // R1: reset values
      @(negedge clk);
      vectors++;
      if (dout !== '0 || done !== 1'b0 || busy !== 1'b0) begin
         miscompares++;
         $display("FAIL R1 reset actual=%h/%b/%b expected=0/0/0", dout, done, busy);
      end
      #1 rst_n = 1'b1;
      @(negedge clk);
      vectors++;
      if (dout !== '0 || done !== 1'b0 || busy !== 1'b0) begin
         miscompares++;
         $display("FAIL R1 post-reset actual=%h/%b/%b expected=0/0/0", dout, done, busy);
      end

      phase = "R2 R3";
      drive(1'b1, 64'h0);
      drive(1'b0, 64'h0);
      repeat (6) drive(1'b0, 64'h0);
      phase = "R6";
      for (int i = 0; i < 6; i++) drive(1'b0, {$urandom, $urandom});

      phase = "R3 R5";
      drive(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
      drive(1'b0, 64'h0);
      while (!e_done) drive(1'b0, 64'h0);
      phase = "R8";
      ld = 1'b1; din = 64'h0123_4567_89AB_CDEF;
      drive(1'b0, 64'h0);
      repeat (7) drive(1'b0, 64'h0);

      phase = "R7";
      drive(1'b1, 64'hDEAD_BEEF_0000_1111);
      drive(1'b0, 64'h0);
      drive(1'b0, 64'h0);
      drive(1'b1, 64'h5555_AAAA_3333_CCCC);
      drive(1'b0, 64'h0);
      drive(1'b0, 64'h0);
      drive(1'b0, 64'h0);
      drive(1'b0, 64'h0);
      drive(1'b1, 64'h8000_0000_0000_0001);
      repeat (8) drive(1'b0, 64'h0);

      phase = "R2";
      drive(1'b1, 64'h1111_2222_3333_4444);
      drive(1'b1, 64'h9999_8888_7777_6666);
      repeat (8) drive(1'b0, 64'h0);

      phase = "R3 R4";
      for (int b = 0; b < 20; b++) begin
         drive(1'b1, {$urandom, $urandom});
         repeat (5 + (b % 3)) drive(1'b0, {$urandom, $urandom});
      end
      repeat (3) drive(1'b0, 64'h0);
      finish_run();
   end
endmodule